// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is a memory-mapped SPI master for one peripheral. Software sets a
clock divider and the SPI mode in a control register, turns on master
operation in a system control register, and then writes one byte to the
transmit register. That write starts a full-duplex 8-bit exchange: the byte
leaves on MOSI most significant bit first while one byte is shifted in from
MISO. Software polls the status register and then reads the received byte.

The serial clock comes from two divider stages. The first divides the system
clock by 16 or 128. The second divides that result by an even factor of
(N+1)*2. One SCK half period is therefore (N+1)*16 or (N+1)*128 system clocks.
The chip select is active low and frames each byte on its own.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register reads 0, spi_cs_n is 1, and spi_sck and spi_mosi are 0.
- R2: The control word at offset 0x00 keeps bits [7:0]: N in [4:0], divider select in bit 5, CPOL in bit 6 and CPHA in bit 7. Master enable is bit 0 at 0x08. Status at 0x04 shows busy in bit 0 and receive-full in bit 2. The received byte is at 0x10 and the transmit byte is written at 0x0C.
- R3: One SCK half period lasts (N+1)*16 clocks when bit 5 is 0 and (N+1)*128 clocks when bit 5 is 1. spi_cs_n stays low for exactly 17 half periods per byte: one half before the first edge, then 16 edges.
- R4: Each byte has exactly 16 SCK edges. The transmit byte appears on MOSI most significant bit first.
- R5: A write to 0x0C while master enable is 0 is ignored: spi_cs_n stays high and status stays 0.
- R6: Status busy reads 1 from the cycle after the transmit write until spi_cs_n rises. A transmit write while busy is ignored and does not change the byte being sent.
- R7: When a byte completes, receive-full is set in the same cycle that spi_cs_n rises, and 0x10 holds the byte taken from MISO, MSB first.
- R8: While spi_cs_n is high, SCK sits at the CPOL level. With CPHA=0, data is sampled on the leading edge and changes on the trailing edge. With CPHA=1, data changes on the leading edge and is sampled on the trailing edge.
- R9: A read of 0x10 clears receive-full. A write to 0x04 with bit 2 at 0 also clears it.
- R10: A byte that completes while receive-full is still set overwrites the receive buffer.
- R11: Bits that no register defines, and every bit at 0x0C and 0x14, read as 0. Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle (used for clear-on-read) |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
The assertions assume that a register write and a read never target the
master enable and transmit registers in the same cycle. They also assume that
CPOL is not rewritten in the cycle right after a frame ends. The stimulus
meets both assumptions because it issues one register access at a time and
changes the control word only while the bus is idle. The peripheral model
drives MISO only on the edges on which the master changes its own data, so
the input is always settled on the sampling edge.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam logic [4:0] OFS_CTRL   = 5'h00;
  localparam logic [4:0] OFS_STAT   = 5'h04;
  localparam logic [4:0] OFS_SYS    = 5'h08;
  localparam logic [4:0] OFS_TXB    = 5'h0C;
  localparam logic [4:0] OFS_RXB    = 5'h10;
  localparam logic [4:0] OFS_CTRL2  = 5'h14;

  typedef struct packed {
    logic       cpha;
    logic       cpol;
    logic       pre_hi;
    logic [4:0] ncnt;
  } ctrl_t;

  // System clocks in one SCK half period.
  function automatic int unsigned half_cycles(input logic [4:0] n, input logic hi,
                                              input int unsigned pre_lo,
                                              input int unsigned pre_hi);
    int unsigned base;
    base = hi ? pre_hi : pre_lo;
    return (int'(n) + 1) * base;
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned PRE_LO = 16,
  parameter int unsigned PRE_HI = 128,
  localparam int CNT_W = $clog2(32 * PRE_HI) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  input  logic [4:0] ncnt,
  input  logic       pre_hi,
  output logic       tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_q;

  assign tick = run && (cnt_q == half_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= CNT_W'(PRE_LO);
    end else if (start) begin
      cnt_q  <= '0;
      half_q <= CNT_W'(spi_pkg::half_cycles(ncnt, pre_hi, PRE_LO, PRE_HI));
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + CNT_W'(1);
    end
  end

  // R3: the half-period counter never passes its limit
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half_q));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int WORD_W = 8,
  localparam int EDGES = 2 * WORD_W,
  localparam int HC_W  = $clog2(EDGES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_byte,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              tick,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_byte
);
  logic [HC_W-1:0]   hc_q, hc_nx;
  logic [WORD_W-1:0] tx_sr, rx_sr;
  logic              cpha_q, odd_edge, smp_edge, shf_edge;

  assign hc_nx    = hc_q + HC_W'(1);
  assign odd_edge = hc_nx[0];
  assign smp_edge = cpha_q ? ~odd_edge : odd_edge;
  assign shf_edge = ~smp_edge && !(cpha_q && hc_nx == HC_W'(1)) && (hc_nx != HC_W'(EDGES));
  assign done     = busy && tick && (hc_nx == HC_W'(EDGES + 1));
  assign mosi     = tx_sr[WORD_W-1];
  assign rx_byte  = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cs_n   <= 1'b1;
      sck    <= 1'b0;
      hc_q   <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      cpha_q <= 1'b0;
    end else if (!busy) begin
      sck <= cpol;
      if (start) begin
        busy   <= 1'b1;
        cs_n   <= 1'b0;
        hc_q   <= '0;
        tx_sr  <= tx_byte;
        cpha_q <= cpha;
      end
    end else if (tick) begin
      hc_q <= hc_nx;
      if (done) begin
        busy <= 1'b0;
        cs_n <= 1'b1;
      end else begin
        sck <= ~sck;
        if (smp_edge) rx_sr <= {rx_sr[WORD_W-2:0], miso};
        if (shf_edge) tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
      end
    end
  end

  // R6: busy and chip select always agree
  a_r6_busy_cs: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);
endmodule

// File: rtl/spi_regs.sv
module spi_regs #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  logic          done,
  input  logic [7:0]    rx_byte,
  output spi_pkg::ctrl_t ctrl,
  output logic          msten,
  output logic          start,
  output logic [7:0]    tx_byte
);
  import spi_pkg::*;
  logic [7:0] rxbuf_q;
  logic       rxfull_q;
  logic       wr_ctrl, wr_stat, wr_sys, wr_tx, rd_rx;

  assign wr_ctrl = reg_wr && (reg_addr == AW'(OFS_CTRL));
  assign wr_stat = reg_wr && (reg_addr == AW'(OFS_STAT));
  assign wr_sys  = reg_wr && (reg_addr == AW'(OFS_SYS));
  assign wr_tx   = reg_wr && (reg_addr == AW'(OFS_TXB));
  assign rd_rx   = reg_rd && (reg_addr == AW'(OFS_RXB));
  assign start   = wr_tx && msten && !busy;
  assign tx_byte = reg_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      msten    <= 1'b0;
      rxbuf_q  <= '0;
      rxfull_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl  <= ctrl_t'(reg_wdata[7:0]);
      if (wr_sys)  msten <= reg_wdata[0];
      if (done) begin
        rxbuf_q  <= rx_byte;
        rxfull_q <= 1'b1;
      end else if (rd_rx || (wr_stat && !reg_wdata[2])) begin
        rxfull_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(OFS_CTRL): reg_rdata[7:0] = ctrl;
      AW'(OFS_STAT): begin reg_rdata[0] = busy; reg_rdata[2] = rxfull_q; end
      AW'(OFS_SYS):  reg_rdata[0] = msten;
      AW'(OFS_RXB):  reg_rdata[7:0] = rxbuf_q;
      default:       reg_rdata = '0;
    endcase
  end

  // R7: a finished byte always leaves receive-full set
  a_r7_full_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rxfull_q);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int unsigned PRE_LO = 16,
  parameter int unsigned PRE_HI = 128,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          spi_sck,
  output logic          spi_mosi,
  output logic          spi_cs_n,
  input  logic          spi_miso
);
  spi_pkg::ctrl_t ctrl;
  logic       msten, start, busy, done, tick;
  logic [7:0] tx_byte, rx_byte;

  spi_regs #(.AW(AW), .DW(DW)) regs_i (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .busy, .done, .rx_byte, .ctrl, .msten, .start, .tx_byte);

  spi_clk_div #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) div_i (
    .clk, .rst_n, .start, .run(busy), .ncnt(ctrl.ncnt), .pre_hi(ctrl.pre_hi), .tick);

  spi_shift_engine #(.WORD_W(8)) eng_i (
    .clk, .rst_n, .start, .tx_byte, .cpol(ctrl.cpol), .cpha(ctrl.cpha), .tick,
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .busy, .done, .rx_byte);

  // Checker state: SCK toggles seen in the current frame
  logic       sck_d;
  logic [5:0] tog_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      tog_cnt <= '0;
    end else begin
      sck_d <= spi_sck;
      if (spi_cs_n && sck_d == spi_sck) tog_cnt <= '0;
      else if (!spi_cs_n && sck_d != spi_sck) tog_cnt <= tog_cnt + 6'd1;
    end
  end

  // R5: a frame only opens with master mode on
  a_r5_start_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> msten);
  // R4: sixteen SCK edges in each frame
  a_r4_sixteen_edges: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (tog_cnt == 6'd16));
  // R8: idle SCK follows CPOL
  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $stable(ctrl.cpol)) |-> (spi_sck == ctrl.cpol));
  // R7: receive-full is set when the frame closes
  a_r7_full_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> reg_rdata_full_q);

  logic reg_rdata_full_q;
  assign reg_rdata_full_q = regs_i.rxfull_q;
endmodule

// File: tb/spi_byte_master_tb_top.sv
module spi_byte_master_tb_top;
  logic        clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, spi_miso = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        spi_sck, spi_mosi, spi_cs_n;
  int checks = 0, errors = 0;
  int lowcnt = 0;
  bit tb_cpha = 0;
  logic [7:0] s_tx = 0, s_rx = 0;
  int s_edges = 0, s_idx = 0;

  always #5 clk = ~clk;

  spi_byte_master dut_i (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
    .reg_rdata, .spi_sck, .spi_mosi, .spi_cs_n, .spi_miso);

  always @(posedge clk) if (!spi_cs_n) lowcnt <= lowcnt + 1;

  // Peripheral model, R8 edge rules
  always @(negedge spi_cs_n) begin
    s_edges = 0; s_rx = 0;
    if (!tb_cpha) begin spi_miso = s_tx[7]; s_idx = 6; end
    else s_idx = 7;
  end
  always @(spi_sck) if (!spi_cs_n) begin
    s_edges++;
    if ((s_edges % 2 == 1) != tb_cpha) s_rx = {s_rx[6:0], spi_mosi};
    else if (s_idx >= 0) begin spi_miso = s_tx[s_idx]; s_idx--; end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask
  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask
  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask
  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 100000; i++) begin
      rd(5'h04, s);
      if (!s[0]) break;
    end
  endtask

  // {ctrl, tx byte, peripheral byte}
  localparam logic [23:0] VEC [6] = '{
    24'h00_A5_3C, 24'h41_81_7E, 24'h80_5A_C3,
    24'hC2_FF_00, 24'h20_01_80, 24'hBF_96_69 };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 cs_n", spi_cs_n, 1); chk("R1 sck", spi_sck, 0); chk("R1 mosi", spi_mosi, 0);
    @(negedge clk) rst_n = 1;
    for (int a = 0; a < 6; a++) begin rd(5'(a * 4), v); chk("R1 reg", v, 0); end

    // R5 ignored without master mode
    wr(5'h0C, 32'h55);
    repeat (40) @(posedge clk); #1;
    chk("R5 cs_n", spi_cs_n, 1);
    rd(5'h04, v); chk("R5 status", v, 0);

    // R11 / R2 unused bits
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, v); chk("R11 ctrl", v, 32'hFF);
    wr(5'h14, 32'hFFFF_FFFF); rd(5'h14, v); chk("R11 ctrl2", v, 0);
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, v); chk("R2 sysctl", v, 1);
    rd(5'h0C, v); chk("R11 txb", v, 0);

    foreach (VEC[k]) begin
      logic [7:0] c, t, p;
      int half;
      {c, t, p} = VEC[k];
      half = ((int'(c[4:0])) + 1) * (c[5] ? 128 : 16);
      wr(5'h00, {24'h0, c});
      tb_cpha = c[7]; s_tx = p;
      repeat (4) @(posedge clk); #1;
      chk("R8 idle sck", spi_sck, c[6]);
      lowcnt = 0;
      wr(5'h0C, {24'h0, t});
      rd(5'h04, v); chk("R6 busy", v[0], 1);
      wait_idle();
      chk("R3 frame cycles", lowcnt, 17 * half);
      chk("R4 mosi byte", s_rx, t);
      rd(5'h04, v); chk("R7 rxfull", v, 32'h4);
      rd(5'h10, v); chk("R7 rx byte", v, p);
      rd(5'h04, v); chk("R9 read clears", v, 0);
      repeat (2) @(posedge clk); #1;
      chk("R8 sck after", spi_sck, c[6]);
    end

    // R6 write while busy ignored; R10 overwrite; R9 status clear
    wr(5'h00, 32'h00); tb_cpha = 0; s_tx = 8'h12;
    wr(5'h0C, 32'hC7);
    repeat (20) @(posedge clk);
    wr(5'h0C, 32'h3B);
    wait_idle();
    chk("R6 busy write ignored", s_rx, 8'hC7);
    s_tx = 8'hE4;
    wr(5'h0C, 32'h18);
    wait_idle();
    rd(5'h04, v); chk("R10 still full", v, 32'h4);
    rd(5'h10, v); chk("R10 overwrite", v, 8'hE4);
    wr(5'h0C, 32'h00); wait_idle();
    wr(5'h04, 32'h0); rd(5'h04, v); chk("R9 status clear", v, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule